// File: doc/BRIEF.md
# DMA Channel Control and Trigger Flags

This block holds the control-side state of a single DMA channel. It captures hardware trigger and sync pulses into sticky flags, which software can set or drop through one-shot strobe bits in a control word. It also tracks two fault conditions, a sync error and a trigger overflow. Halt, run and soft-reset commands are ordered against the datapath's in-progress read-write access, so a stop never cuts an access in half.

Software writes a control word with `wr_en`. The strobe bits act only in the cycle of the write and are not stored. The enable bit is stored by every write. The datapath reports `acc_busy` while an access is in flight and `burst_go` when a burst starts. The block returns `burst_req` to ask for a burst and `cnt_clr` to zero the channel's burst, transfer and wrap counters after a soft reset.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `trig_flag`, `sync_flag`, `sync_err`, `ovf_flag`, `run_sts`, `burst_req` and `cnt_clr` are all 0.
- R2: A `trig_in` pulse sets `trig_flag` and a `sync_in` pulse sets `sync_flag` at the next clock edge. A `burst_go` pulse clears both flags at the next edge.
- R3: In a write, bit 3 forces `trig_flag` to 1, bit 4 clears it, bit 5 forces `sync_flag` to 1 and bit 6 clears it. These strobes act only in the write cycle.
- R4: A hardware pulse in the same cycle as a clear of its flag leaves the flag at 1. The clear may come from a strobe or from `burst_go`.
- R5: Write bit 7 clears both `sync_err` and `ovf_flag`. An `err_in` or `ovf_in` pulse in the same cycle wins, and that flag stays at 1.
- R6: `sync_err` is set by `err_in`, or by `sync_in` while `sync_flag` is already 1. `ovf_flag` is set by `ovf_in`, or by `trig_in` while `trig_flag` is already 1.
- R7: Every write stores bit 8 as the trigger enable. `burst_req` is 1 exactly when `run_sts`, the stored enable and `trig_flag` are all 1. This means a forced trigger with the enable set requests a burst.
- R8: Write bit 0 sets `run_sts` when bits 1 and 2 of the same word are 0 and no soft reset is pending. It also cancels a pending halt.
- R9: Write bit 1 requests a halt. The halt drops `run_sts` at the first clock edge at which `acc_busy` is 0, and `run_sts` holds its value until then.
- R10: Write bit 2 requests a soft reset, which waits on `acc_busy` in the same way as a halt. When it takes effect, `run_sts` goes to 0, any pending halt is discarded, and `cnt_clr` is 1 for exactly one cycle, in the same cycle that `run_sts` first reads 0. A soft reset wins over a halt, and run writes are ignored while a soft reset is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 9 | Control word: bits 0..8 as in R3, R5, R7 to R10 |
| trig_in | input | 1 | Peripheral trigger pulse |
| sync_in | input | 1 | Sync event pulse |
| err_in | input | 1 | External sync-error pulse |
| ovf_in | input | 1 | External overflow pulse |
| burst_go | input | 1 | First burst transfer is starting |
| acc_busy | input | 1 | Datapath read-write access in progress |
| trig_flag | output | 1 | Latched peripheral trigger |
| sync_flag | output | 1 | Latched sync event |
| sync_err | output | 1 | Sync-error flag |
| ovf_flag | output | 1 | Trigger-overflow flag |
| run_sts | output | 1 | Channel running |
| burst_req | output | 1 | Burst request to the datapath |
| cnt_clr | output | 1 | One-cycle clear for the channel counters |

## Verification
The bench drives a trigger pulse in the same cycle as each kind of clear: a strobe, `burst_go`, and the error clear paired with a fault pulse. A design that gives the clear priority would lose an event that really happened. It holds `acc_busy` high across halt and soft-reset writes and checks that `run_sts` stays at 1 until the busy cycle ends. A design that acts at once would abort a live access. It requests a halt and a soft reset together, then runs the channel again afterwards. A design that leaves the halt pending would stop the restarted channel without any new command. It also checks that `cnt_clr` is a single pulse and that a run write sent while a soft reset is pending has no effect.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned WORD_W    = 9;
  // control word bit positions
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_HALT    = 1;
  localparam int unsigned B_SRST    = 2;
  localparam int unsigned B_TFORCE  = 3;
  localparam int unsigned B_TCLEAR  = 4;
  localparam int unsigned B_SFORCE  = 5;
  localparam int unsigned B_SCLEAR  = 6;
  localparam int unsigned B_ECLEAR  = 7;
  localparam int unsigned B_TEN     = 8;
  // flag bank slots
  localparam int unsigned F_TRIG    = 0;
  localparam int unsigned F_SYNC    = 1;
  localparam int unsigned F_SERR    = 2;
  localparam int unsigned F_OVF     = 3;
  localparam int unsigned NFLAG     = 4;
endpackage

// File: rtl/dcc_flag_bank.sv
module dcc_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_nxt;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set dominates any clear source
    always_comb begin
      if (set_i[g])      q_nxt[g] = 1'b1;
      else if (clr_i[g]) q_nxt[g] = 1'b0;
      else               q_nxt[g] = q_o[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= q_nxt[g];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]); // R4
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]); // R3
  end
endmodule

// File: rtl/dcc_run_seq.sv
module dcc_run_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic run_wr,
  input  logic halt_wr,
  input  logic srst_wr,
  input  logic busy,
  output logic run_sts,
  output logic cnt_clr
);
  logic halt_pend, srst_pend;
  logic halt_req, srst_req, srst_apply, halt_apply, run_ok;
  logic run_nxt, halt_pend_nxt, srst_pend_nxt, cnt_clr_nxt;

  always_comb begin
    halt_req      = halt_pend | halt_wr;
    srst_req      = srst_pend | srst_wr;
    srst_apply    = srst_req & ~busy;
    halt_apply    = halt_req & ~busy & ~srst_req;
    run_ok        = run_wr & ~halt_wr & ~srst_wr & ~srst_req;

    if (srst_apply || halt_apply) run_nxt = 1'b0;
    else if (run_ok)              run_nxt = 1'b1;
    else                          run_nxt = run_sts;

    if (srst_apply || halt_apply || run_ok) halt_pend_nxt = 1'b0;
    else                                    halt_pend_nxt = halt_req;

    srst_pend_nxt = srst_req & ~srst_apply;
    cnt_clr_nxt   = srst_apply;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sts   <= 1'b0;
      halt_pend <= 1'b0;
      srst_pend <= 1'b0;
      cnt_clr   <= 1'b0;
    end else begin
      run_sts   <= run_nxt;
      halt_pend <= halt_pend_nxt;
      srst_pend <= srst_pend_nxt;
      cnt_clr   <= cnt_clr_nxt;
    end
  end

  AST_BUSY_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_sts) |=> run_sts); // R9
  AST_STOP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_sts && !run_nxt) |-> !busy); // R9
  AST_CLR_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> !run_sts); // R10
  AST_NO_RUN_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_pend && !run_sts) |=> !run_sts); // R10
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              trig_in,
  input  logic              sync_in,
  input  logic              err_in,
  input  logic              ovf_in,
  input  logic              burst_go,
  input  logic              acc_busy,
  output logic              trig_flag,
  output logic              sync_flag,
  output logic              sync_err,
  output logic              ovf_flag,
  output logic              run_sts,
  output logic              burst_req,
  output logic              cnt_clr
);
  logic             trig_en, trig_en_nxt;
  logic [NFLAG-1:0] f_set, f_clr, f_q;
  logic             s_tforce, s_tclear, s_sforce, s_sclear, s_eclear;

  always_comb begin
    s_tforce = wr_en & wr_data[B_TFORCE];
    s_tclear = wr_en & wr_data[B_TCLEAR];
    s_sforce = wr_en & wr_data[B_SFORCE];
    s_sclear = wr_en & wr_data[B_SCLEAR];
    s_eclear = wr_en & wr_data[B_ECLEAR];

    f_set[F_TRIG] = trig_in | s_tforce;
    f_clr[F_TRIG] = s_tclear | burst_go;
    f_set[F_SYNC] = sync_in | s_sforce;
    f_clr[F_SYNC] = s_sclear | burst_go;
    f_set[F_SERR] = err_in | (sync_in & f_q[F_SYNC]);
    f_clr[F_SERR] = s_eclear;
    f_set[F_OVF]  = ovf_in | (trig_in & f_q[F_TRIG]);
    f_clr[F_OVF]  = s_eclear;

    trig_en_nxt = wr_en ? wr_data[B_TEN] : trig_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_en <= 1'b0;
    else        trig_en <= trig_en_nxt;
  end

  dcc_flag_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (f_set),
    .clr_i (f_clr),
    .q_o   (f_q)
  );

  dcc_run_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_wr  (wr_en & wr_data[B_RUN]),
    .halt_wr (wr_en & wr_data[B_HALT]),
    .srst_wr (wr_en & wr_data[B_SRST]),
    .busy    (acc_busy),
    .run_sts (run_sts),
    .cnt_clr (cnt_clr)
  );

  assign trig_flag = f_q[F_TRIG];
  assign sync_flag = f_q[F_SYNC];
  assign sync_err  = f_q[F_SERR];
  assign ovf_flag  = f_q[F_OVF];
  assign burst_req = run_sts & trig_en & trig_flag;

  AST_DOUBLE_TRIG_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && trig_flag) |=> ovf_flag); // R6
  AST_DOUBLE_SYNC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && sync_flag) |=> sync_err); // R6
  AST_BURST_DROPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_go && !trig_in && !s_tforce) |=> !trig_flag); // R2
  AST_ECLR_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_eclear && ovf_in) |=> ovf_flag); // R5
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (run_sts && trig_flag)); // R7
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       trig_in = 1'b0, sync_in = 1'b0, err_in = 1'b0, ovf_in = 1'b0;
  logic       burst_go = 1'b0, acc_busy = 1'b0;
  logic       trig_flag, sync_flag, sync_err, ovf_flag, run_sts, burst_req, cnt_clr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trig_in(trig_in), .sync_in(sync_in), .err_in(err_in), .ovf_in(ovf_in),
    .burst_go(burst_go), .acc_busy(acc_busy),
    .trig_flag(trig_flag), .sync_flag(sync_flag), .sync_err(sync_err),
    .ovf_flag(ovf_flag), .run_sts(run_sts), .burst_req(burst_req), .cnt_clr(cnt_clr)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one-cycle write; returns after the update edge
  task automatic wr(logic [8:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 trig_flag", trig_flag, 1'b0);
    chk("R1 sync_flag", sync_flag, 1'b0);
    chk("R1 sync_err", sync_err, 1'b0);
    chk("R1 ovf_flag", ovf_flag, 1'b0);
    chk("R1 run_sts", run_sts, 1'b0);
    chk("R1 burst_req", burst_req, 1'b0);
    chk("R1 cnt_clr", cnt_clr, 1'b0);
  endtask

  task automatic t_hw_flags();
    trig_in = 1; tick(); trig_in = 0;
    chk("R2 trig set", trig_flag, 1'b1);
    sync_in = 1; tick(); sync_in = 0;
    chk("R2 sync set", sync_flag, 1'b1);
    chk("R6 no err on first sync", sync_err, 1'b0);
    burst_go = 1; tick(); burst_go = 0;
    chk("R2 burst clears trig", trig_flag, 1'b0);
    chk("R2 burst clears sync", sync_flag, 1'b0);
  endtask

  task automatic t_force_clear();
    wr(9'h008);
    chk("R3 trig force", trig_flag, 1'b1);
    tick();
    chk("R3 force not stored", trig_flag, 1'b1);
    wr(9'h010);
    chk("R3 trig clear", trig_flag, 1'b0);
    wr(9'h020);
    chk("R3 sync force", sync_flag, 1'b1);
    wr(9'h040);
    chk("R3 sync clear", sync_flag, 1'b0);
  endtask

  task automatic t_collide();
    trig_in = 1; wr(9'h010); trig_in = 0;
    chk("R4 trig beats clear", trig_flag, 1'b1);
    sync_in = 1; wr(9'h040); sync_in = 0;
    chk("R4 sync beats clear", sync_flag, 1'b1);
    wr(9'h050);
    trig_in = 1; burst_go = 1; tick(); trig_in = 0; burst_go = 0;
    chk("R4 trig beats burst", trig_flag, 1'b1);
    wr(9'h010);
  endtask

  task automatic t_faults();
    sync_in = 1; tick(); tick(); sync_in = 0;
    chk("R6 double sync", sync_err, 1'b1);
    trig_in = 1; tick(); tick(); trig_in = 0;
    chk("R6 double trig", ovf_flag, 1'b1);
    ovf_in = 1; wr(9'h080); ovf_in = 0;
    chk("R5 ovf beats clear", ovf_flag, 1'b1);
    chk("R5 clear sync_err", sync_err, 1'b0);
    wr(9'h080);
    chk("R5 clear ovf", ovf_flag, 1'b0);
    err_in = 1; tick(); err_in = 0;
    chk("R6 err_in sets", sync_err, 1'b1);
    wr(9'h0D0);
    chk("R5 clear again", sync_err, 1'b0);
  endtask

  task automatic t_request();
    wr(9'h101);
    chk("R8 run set", run_sts, 1'b1);
    chk("R7 no req w/o flag", burst_req, 1'b0);
    wr(9'h108);
    chk("R7 forced request", burst_req, 1'b1);
    wr(9'h000);
    chk("R7 enable off", burst_req, 1'b0);
    chk("R7 flag kept", trig_flag, 1'b1);
    wr(9'h100);
    chk("R7 enable on", burst_req, 1'b1);
    burst_go = 1; tick(); burst_go = 0;
    chk("R7 burst drops req", burst_req, 1'b0);
  endtask

  task automatic t_halt();
    acc_busy = 1;
    wr(9'h102);
    chk("R9 halt waits", run_sts, 1'b1);
    tick(); tick();
    chk("R9 still busy", run_sts, 1'b1);
    acc_busy = 0; tick();
    chk("R9 halt applied", run_sts, 1'b0);
    wr(9'h101);
    chk("R8 rerun", run_sts, 1'b1);
    wr(9'h003);
    chk("R8 halt wins same word", run_sts, 1'b0);
    wr(9'h001);
  endtask

  task automatic t_srst();
    acc_busy = 1;
    wr(9'h006);
    tick();
    chk("R10 srst waits", run_sts, 1'b1);
    chk("R10 no early clr", cnt_clr, 1'b0);
    acc_busy = 0; tick();
    chk("R10 srst stops", run_sts, 1'b0);
    chk("R10 clr pulse", cnt_clr, 1'b1);
    tick();
    chk("R10 clr single", cnt_clr, 1'b0);
    wr(9'h001); tick();
    chk("R10 halt discarded", run_sts, 1'b1);
    acc_busy = 1;
    wr(9'h004);
    wr(9'h001);
    chk("R10 run ignored pending", run_sts, 1'b1);
    acc_busy = 0; tick();
    chk("R10 second srst", run_sts, 1'b0);
    wr(9'h001);
    chk("R8 run after srst", run_sts, 1'b1);
  endtask

  initial begin
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_hw_flags();
    t_force_clear();
    t_collide();
    t_faults();
    t_request();
    t_halt();
    t_srst();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule